// File: doc/BRIEF.md
# DDR PHY Bring-Up Step Sequencer

This block walks a DDR physical layer through its power-on bring-up. Software writes one 32-bit trigger word that selects the steps to run. The sequencer then runs the selected steps one after another. Each step lasts for a cycle count taken from a timing input. The analog parts (delay-locked loop, impedance calibration, training comparators) are not modelled. A step is represented only by its duration. The two training steps also sample a pass/fail stub input when they finish.

The steps, with the trigger bit that selects each one, are:

| Bit | Step |
|-----|------|
| 1 | DLL soft reset |
| 2 | DLL lock wait |
| 3 | impedance calibration |
| 4 | interface-timing reset |
| 5 | DRAM reset (requested for DDR3, left out for LPDDR3) |
| 6 | DRAM init, in four timed phases |
| 7 | DQS gate training |
| 8 | read-valid training |

The same word also carries:

- bit 0, the start bit, which must be set for anything to run;
- bit 28, which clears all status flags;
- bits 29 and 30, which bypass the lock wait and the calibration.

Progress is reported in a sticky 10-bit status vector. The vector also reports which step is running and which DRAM-init phase is active.

Top module: `phy_init_seq`

## Requirements
- R1: After reset, `status_o` is 0, `busy_o` is 0, `cur_step_o` is 0 and `init_phase_o` is 0.
- R2: A trigger write with bit 0 clear starts no step: `busy_o` stays 0 and no status flag is set. Bit 28 in that same word is still honoured.
- R3: Selected steps run in ascending bit order. Step codes are the trigger bit numbers 1 to 8, and `cur_step_o` shows the code of the running step. A write is accepted at edge E0, which raises `busy_o`. The first step shows from edge E0+1. Each step holds for its programmed number of cycles. `busy_o` falls at edge E0+1+S, where S is the sum of the durations of the steps that run.
- R4: A step whose trigger bit is clear takes no cycles and is never shown on `cur_step_o`. For example, an LPDDR3 word without bit 5 runs no DRAM reset.
- R5: Bit 29 together with bit 2 skips the lock wait, and bit 30 together with bit 3 skips calibration. The skipped step's done flag (status bit 1 or bit 2) is set at edge E0+1.
- R6: Status flags are set as follows, at the edge where the step ends:
  - bit 1 at the end of the lock wait;
  - bit 2 at the end of calibration;
  - bit 3 at the end of DRAM-init phase 3;
  - bit 4 at the end of each training step that passes;
  - bit 0 when the whole sequence ends without a training failure.
- R7: DRAM init (code 6) runs four phases in order. `init_phase_o` counts 0 to 3, and phase n lasts `t_dinitn` cycles. Outside step 6, `init_phase_o` is 0.
- R8: If `qs_fail_i` is high when gate training ends, status bit 5 is set. If `rv_fail_i` is high when read-valid training ends, status bit 8 is set. In either case the sequence stops at that edge: `busy_o` and `cur_step_o` return to 0, no later step runs, and bit 0 is not set.
- R9: An accepted write with bit 28 set clears every status flag at edge E0, before the new sequence starts.
- R10: Status flags are sticky. A flag falls only through reset or an accepted clear.
- R11: A trigger write while `busy_o` is high is ignored entirely, including its start and clear bits.
- R12: A duration input of 0 is treated as 1 cycle.
- R13: Status bits 6, 7 and 9 (intermittent and drift errors, which have no source here) are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_we | input | 1 | Trigger word write strobe |
| trig_data | input | 32 | Trigger word: step bits 0-8, clear 28, bypasses 29/30 |
| t_dll_srst | input | CW | DLL soft-reset cycles |
| t_dll_lock | input | CW | DLL lock-wait cycles |
| t_zcal | input | CW | Impedance calibration cycles |
| t_itm_srst | input | CW | Interface-timing reset cycles |
| t_dram_rst | input | CW | DRAM reset cycles |
| t_dinit0 | input | CW | DRAM-init phase 0 cycles |
| t_dinit1 | input | CW | DRAM-init phase 1 cycles |
| t_dinit2 | input | CW | DRAM-init phase 2 cycles |
| t_dinit3 | input | CW | DRAM-init phase 3 cycles |
| t_train | input | CW | Cycles per training step |
| qs_fail_i | input | 1 | Gate-training fail stub, sampled at step end |
| rv_fail_i | input | 1 | Read-valid training fail stub, sampled at step end |
| busy_o | output | 1 | Sequence in progress |
| cur_step_o | output | 4 | Code of the running step, 0 when none |
| init_phase_o | output | 2 | Active DRAM-init phase |
| status_o | output | 10 | Sticky done/error flags |

## Verification
The bench attacks the following corner cases:

- **Full DDR3 word and LPDDR3 word without bit 5.** A sequencer that ignored the step mask would show code 5 and stretch `busy_o`.
- **Bypass bits.** A design that let the bypasses leak would either stall in the lock wait or leave status bits 1 and 2 low.
- **Failing gate training.** A sequencer that did not stop on the failure would go on to read-valid training and set bit 0.
- **Writes issued mid-run.** A design that accepted these would restart, or would wipe flags.
- **Clear-only words and start-less words.** A design that honoured bit 0 wrongly, or ordered the clear after the set, would show the wrong status.
- **A zero duration.** A design that treated it as zero cycles, or let the counter wrap, would change the busy length by one cycle, or by about a million cycles.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int NSTEP      = 8;
  localparam int CODE_W     = 4;
  localparam int STAT_W     = 10;
  localparam int START_BIT  = 0;
  localparam int CLR_BIT    = 28;
  localparam int BYP_LOCK   = 29;
  localparam int BYP_CAL    = 30;

  localparam logic [CODE_W-1:0] C_NONE   = 4'd0;
  localparam logic [CODE_W-1:0] C_LOCK   = 4'd2;
  localparam logic [CODE_W-1:0] C_CAL    = 4'd3;
  localparam logic [CODE_W-1:0] C_DINIT  = 4'd6;
  localparam logic [CODE_W-1:0] C_GATE   = 4'd7;
  localparam logic [CODE_W-1:0] C_RVAL   = 4'd8;

  localparam int F_INIT  = 0;
  localparam int F_DLL   = 1;
  localparam int F_CAL   = 2;
  localparam int F_DINIT = 3;
  localparam int F_TRAIN = 4;
  localparam int F_QSERR = 5;
  localparam int F_RVERR = 8;
endpackage

// File: rtl/phy_seq_pick.sv
module phy_seq_pick #(
  parameter int N  = 8,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] code,
  output logic          any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_chain
      assign gnt[gi]    = req[gi] & ~seen[gi];
      assign seen[gi+1] = seen[gi] | req[gi];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++)
      if (gnt[i]) code = IW'(i + 1);
  end
endmodule

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/phy_seq_flags.sv
module phy_seq_flags #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] set,
  output logic [W-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst)      flags <= '0;
    else if (clr) flags <= set;
    else          flags <= flags | set;
  end
endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
  import phy_seq_pkg::*;
#(
  parameter int CW = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_we,
  input  logic [31:0]       trig_data,
  input  logic [CW-1:0]     t_dll_srst,
  input  logic [CW-1:0]     t_dll_lock,
  input  logic [CW-1:0]     t_zcal,
  input  logic [CW-1:0]     t_itm_srst,
  input  logic [CW-1:0]     t_dram_rst,
  input  logic [CW-1:0]     t_dinit0,
  input  logic [CW-1:0]     t_dinit1,
  input  logic [CW-1:0]     t_dinit2,
  input  logic [CW-1:0]     t_dinit3,
  input  logic [CW-1:0]     t_train,
  input  logic              qs_fail_i,
  input  logic              rv_fail_i,
  output logic              busy_o,
  output logic [3:0]        cur_step_o,
  output logic [1:0]        init_phase_o,
  output logic [9:0]        status_o
);
  localparam int NPH = 4;

  logic              busy_q, nxt_busy;
  logic [CODE_W-1:0] code_q, nxt_code;
  logic [1:0]        phase_q, nxt_phase;
  logic [NSTEP-1:0]  pend_q, nxt_pend;
  logic              byp_lock_q, byp_cal_q;

  logic              accept, step_end, fail;
  logic              ld;
  logic [CW-1:0]     ld_val;
  logic              tmr_zero;
  logic [STAT_W-1:0] set_mask;
  logic              clr;

  logic [NSTEP-1:0]  gnt;
  logic [CODE_W-1:0] pick_code;
  logic              pick_any;

  logic [CW-1:0]     dur_tab [NSTEP];
  logic [CW-1:0]     ph_tab  [NPH];
  logic [NSTEP-1:0]  start_mask;

  assign dur_tab[0] = t_dll_srst;
  assign dur_tab[1] = t_dll_lock;
  assign dur_tab[2] = t_zcal;
  assign dur_tab[3] = t_itm_srst;
  assign dur_tab[4] = t_dram_rst;
  assign dur_tab[5] = t_dinit0;
  assign dur_tab[6] = t_train;
  assign dur_tab[7] = t_train;

  assign ph_tab[0] = t_dinit0;
  assign ph_tab[1] = t_dinit1;
  assign ph_tab[2] = t_dinit2;
  assign ph_tab[3] = t_dinit3;

  function automatic logic [CW-1:0] ticks(input logic [CW-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  // bypassed steps never enter the pending mask
  always_comb begin
    start_mask = trig_data[NSTEP:1];
    if (trig_data[BYP_LOCK]) start_mask[C_LOCK-1] = 1'b0;
    if (trig_data[BYP_CAL])  start_mask[C_CAL-1]  = 1'b0;
  end

  phy_seq_pick #(.N(NSTEP), .IW(CODE_W)) u_pick (
    .req  (pend_q),
    .gnt  (gnt),
    .code (pick_code),
    .any  (pick_any)
  );

  phy_seq_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .zero     (tmr_zero)
  );

  phy_seq_flags #(.W(STAT_W)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .set   (set_mask),
    .flags (status_o)
  );

  always_comb begin
    accept    = trig_we & ~busy_q;
    step_end  = busy_q & ((code_q == C_NONE) | tmr_zero);
    clr       = accept & trig_data[CLR_BIT];
    nxt_busy  = busy_q;
    nxt_code  = code_q;
    nxt_phase = phase_q;
    nxt_pend  = pend_q;
    ld        = 1'b0;
    ld_val    = '0;
    set_mask  = '0;
    fail      = 1'b0;
    if (accept && trig_data[START_BIT]) begin
      nxt_busy  = 1'b1;
      nxt_code  = C_NONE;
      nxt_phase = 2'd0;
      nxt_pend  = start_mask;
    end else if (step_end) begin
      if (code_q == C_NONE) begin
        if (byp_lock_q) set_mask[F_DLL] = 1'b1;
        if (byp_cal_q)  set_mask[F_CAL] = 1'b1;
      end
      if (code_q == C_DINIT && phase_q != 2'(NPH - 1)) begin
        nxt_phase = phase_q + 2'd1;
        ld        = 1'b1;
        ld_val    = ticks(ph_tab[phase_q + 2'd1]);
      end else begin
        case (code_q)
          C_LOCK:  set_mask[F_DLL]   = 1'b1;
          C_CAL:   set_mask[F_CAL]   = 1'b1;
          C_DINIT: set_mask[F_DINIT] = 1'b1;
          C_GATE: begin
            fail = qs_fail_i;
            if (qs_fail_i) set_mask[F_QSERR] = 1'b1;
            else           set_mask[F_TRAIN] = 1'b1;
          end
          C_RVAL: begin
            fail = rv_fail_i;
            if (rv_fail_i) set_mask[F_RVERR] = 1'b1;
            else           set_mask[F_TRAIN] = 1'b1;
          end
          default: ;
        endcase
        if (fail) begin
          nxt_busy  = 1'b0;
          nxt_code  = C_NONE;
          nxt_phase = 2'd0;
          nxt_pend  = '0;
        end else if (pick_any) begin
          nxt_code  = pick_code;
          nxt_phase = 2'd0;
          nxt_pend  = pend_q & ~gnt;
          ld        = 1'b1;
          ld_val    = ticks(dur_tab[pick_code - 4'd1]);
        end else begin
          nxt_busy  = 1'b0;
          nxt_code  = C_NONE;
          nxt_phase = 2'd0;
          set_mask[F_INIT] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      code_q     <= C_NONE;
      phase_q    <= 2'd0;
      pend_q     <= '0;
      byp_lock_q <= 1'b0;
      byp_cal_q  <= 1'b0;
    end else begin
      busy_q  <= nxt_busy;
      code_q  <= nxt_code;
      phase_q <= nxt_phase;
      pend_q  <= nxt_pend;
      if (accept && trig_data[START_BIT]) begin
        byp_lock_q <= trig_data[C_LOCK] & trig_data[BYP_LOCK];
        byp_cal_q  <= trig_data[C_CAL]  & trig_data[BYP_CAL];
      end
    end
  end

  assign busy_o       = busy_q;
  assign cur_step_o   = code_q;
  assign init_phase_o = phase_q;
endmodule

// File: rtl/phy_init_seq_chk.sv
module phy_init_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        trig_we,
  input logic [31:0] trig_data,
  input logic        busy_o,
  input logic [3:0]  cur_step_o,
  input logic [1:0]  init_phase_o,
  input logic [9:0]  status_o
);
  // R2
  no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && trig_we && !trig_data[0]) |=> !busy_o);

  // R3
  ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cur_step_o != 4'd0 && cur_step_o != $past(cur_step_o) && $past(cur_step_o) != 4'd0)
      |-> (cur_step_o > $past(cur_step_o)));

  // R3
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (cur_step_o == 4'd0));

  // R7
  phase_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_step_o != 4'd6) |-> (init_phase_o == 2'd0));

  // R8
  qs_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[5]) |-> !busy_o);

  // R8
  rv_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[8]) |-> !busy_o);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && trig_we && trig_data[28]) |=> (status_o == 10'd0));

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(!busy_o && trig_we && trig_data[28]) |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

bind phy_init_seq phy_init_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .trig_we      (trig_we),
  .trig_data    (trig_data),
  .busy_o       (busy_o),
  .cur_step_o   (cur_step_o),
  .init_phase_o (init_phase_o),
  .status_o     (status_o)
);

// File: tb/sim_phy_init_seq.sv
`timescale 1ns/1ps
module sim_phy_init_seq;
  localparam int CW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_we = 1'b0;
  logic [31:0] trig_data = '0;
  logic [CW-1:0] t_dll_srst = 20'd27, t_dll_lock = 20'd2750, t_zcal = 20'd30,
                 t_itm_srst = 20'd8,  t_dram_rst = 20'd20,
                 t_dinit0 = 20'd400, t_dinit1 = 20'd21, t_dinit2 = 20'd300,
                 t_dinit3 = 20'd53, t_train = 20'd16;
  logic qs_fail_i = 1'b0, rv_fail_i = 1'b0;
  logic busy_o;
  logic [3:0] cur_step_o;
  logic [1:0] init_phase_o;
  logic [9:0] status_o;

  always #2.5 clk = ~clk;

  phy_init_seq #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .trig_we(trig_we), .trig_data(trig_data),
    .t_dll_srst(t_dll_srst), .t_dll_lock(t_dll_lock), .t_zcal(t_zcal),
    .t_itm_srst(t_itm_srst), .t_dram_rst(t_dram_rst),
    .t_dinit0(t_dinit0), .t_dinit1(t_dinit1), .t_dinit2(t_dinit2), .t_dinit3(t_dinit3),
    .t_train(t_train), .qs_fail_i(qs_fail_i), .rv_fail_i(rv_fail_i),
    .busy_o(busy_o), .cur_step_o(cur_step_o), .init_phase_o(init_phase_o),
    .status_o(status_o)
  );

  typedef struct packed {
    logic       b;
    logic [3:0] c;
    logic [1:0] p;
    logic [9:0] s;
  } exp_t;

  exp_t e = '0;
  exp_t tl[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  function automatic int dur(input int k, input int p);
    int d;
    case (k)
      1: d = t_dll_srst;
      2: d = t_dll_lock;
      3: d = t_zcal;
      4: d = t_itm_srst;
      5: d = t_dram_rst;
      6: d = (p == 0) ? t_dinit0 : (p == 1) ? t_dinit1 : (p == 2) ? t_dinit2 : t_dinit3;
      default: d = t_train;
    endcase
    return (d == 0) ? 1 : d;
  endfunction

  task automatic push_n(input int n, input exp_t x);
    for (int i = 0; i < n; i++) tl.push_back(x);
  endtask

  // reference timeline: one entry per clock edge after acceptance
  task automatic build(input logic [31:0] w);
    logic [9:0] st;
    st = e.s;
    if (w[28]) st = '0;
    if (!w[0]) begin
      tl.push_back({1'b0, 4'd0, 2'd0, st});
      return;
    end
    tl.push_back({1'b1, 4'd0, 2'd0, st});
    if (w[2] && w[29]) st[1] = 1'b1;
    if (w[3] && w[30]) st[2] = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      if (!w[k]) continue;
      if (k == 2 && w[29]) continue;
      if (k == 3 && w[30]) continue;
      if (k == 6) begin
        for (int p = 0; p < 4; p++) push_n(dur(6, p), {1'b1, 4'd6, 2'(p), st});
        st[3] = 1'b1;
      end else begin
        push_n(dur(k, 0), {1'b1, 4'(k), 2'd0, st});
        if (k == 2) st[1] = 1'b1;
        if (k == 3) st[2] = 1'b1;
        if (k == 7) begin
          if (qs_fail_i) begin st[5] = 1'b1; tl.push_back({1'b0, 4'd0, 2'd0, st}); return; end
          st[4] = 1'b1;
        end
        if (k == 8) begin
          if (rv_fail_i) begin st[8] = 1'b1; tl.push_back({1'b0, 4'd0, 2'd0, st}); return; end
          st[4] = 1'b1;
        end
      end
    end
    st[0] = 1'b1;
    tl.push_back({1'b0, 4'd0, 2'd0, st});
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      e = '0;
      tl.delete();
    end else if (tl.size() > 0) begin
      e = tl.pop_front();
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if ({busy_o, cur_step_o, init_phase_o, status_o} !== e) begin
        errors++;
        $display("FAIL %s: busy=%0b step=%0d phase=%0d status=%h expected busy=%0b step=%0d phase=%0d status=%h",
                 cur_req, busy_o, cur_step_o, init_phase_o, status_o, e.b, e.c, e.p, e.s);
      end
    end
  end

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    trig_we = 1'b1;
    trig_data = w;
    if (tl.size() == 0 && !e.b) build(w);
    @(negedge clk);
    trig_we = 1'b0;
    trig_data = '0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tl.size() != 0 || e.b) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    cur_req = "R1";
    repeat (3) @(negedge clk);

    // R3 R6 R7: full DDR3 word, all steps 1..8
    cur_req = "R3";
    wr(32'h0000_01FF);
    wait_idle();

    // R4: LPDDR3 style, no DRAM reset, after clearing
    cur_req = "R4";
    wr(32'h1000_01DF);
    wait_idle();

    // R5: lock and calibration bypassed
    cur_req = "R5";
    wr(32'h7000_000F);
    wait_idle();

    // R2: no start bit
    cur_req = "R2";
    wr(32'h0000_01FE);
    wait_idle();

    // R11: writes while busy are ignored
    cur_req = "R11";
    wr(32'h1000_0013);
    repeat (5) @(negedge clk);
    wr(32'h1000_0001);
    wait_idle();

    // R10: flags persist over a later run
    cur_req = "R10";
    wr(32'h0000_0003);
    wait_idle();

    // R9: clear-only word, then clear plus start
    cur_req = "R9";
    wr(32'h1000_0000);
    wait_idle();
    wr(32'h1000_0003);
    wait_idle();

    // R8: gate training fails, read-valid never runs
    cur_req = "R8";
    qs_fail_i = 1'b1;
    wr(32'h1000_0181);
    wait_idle();
    qs_fail_i = 1'b0;
    rv_fail_i = 1'b1;
    wr(32'h1000_0181);
    wait_idle();
    rv_fail_i = 1'b0;

    // R12: zero duration counts as one cycle
    cur_req = "R12";
    t_itm_srst = 20'd0;
    t_dinit1 = 20'd0;
    wr(32'h1000_0051);
    wait_idle();

    // R13: unsourced error bits stay low
    cur_req = "R13";
    checks++;
    if (status_o[6] !== 1'b0 || status_o[7] !== 1'b0 || status_o[9] !== 1'b0) begin
      errors++;
      $display("FAIL R13: bits6/7/9=%b%b%b expected 000", status_o[6], status_o[7], status_o[9]);
    end
    finish_run();
  end
endmodule